// File: doc/BRIEF.md
# Cache Flush Special-Cycle Sequencer

This block carries out a complete writeback-and-invalidate sweep of a processor's two on-chip caches in response to a single flush command. It steps through every entry of the data cache tag store in ascending index order. A line whose state is modified is first copied to memory as a four-beat burst of 64-bit beats and then invalidated. A line in any other state is invalidated at once, with no bus traffic. After the data cache it steps through the instruction cache, whose lines are never dirty, and invalidates each one.

Once both caches are clean and empty, the block announces the completed flush to the system with two special bus cycles in a fixed order. The first carries byte enables F7h (writeback-and-invalidate). The second carries FDh (invalidate only). Each cycle stays on the bus until the system returns its own ready. One clock after the ready of the second cycle, a single-cycle done pulse is issued. The tag stores and the line data are read through combinational ports, indexed by outputs of this block.

Top module: `cflush_sequencer`

## Requirements
- R1: While reset is held and in the idle state afterwards, bus_cyc, flush_done, dc_inval and ic_inval are all low.
- R2: Each flush invalidates every data cache line exactly once, with dc_inval high and dc_idx ascending from 0. It then invalidates every instruction cache line exactly once, with ic_inval high and ic_idx ascending from 0. The two strobes are never high together.
- R3: A data line reporting dc_modified high is written back as exactly four bus beats before its dc_inval. A line reporting dc_modified low causes no bus cycle. No invalidate strobe is high while bus_cyc is high.
- R4: A writeback beat drives bus_addr[31:5] equal to the line's dc_tag, and bus_addr[4:3] equal to the beat number, ascending 0,1,2,3. It also drives bus_be = FFh, bus_wr = 1, bus_mem = 1 and bus_data = 1. bus_wdata equals ld_data for ld_beat equal to that beat number.
- R5: A bus cycle advances only on a clock edge where bus_rdy is high. While bus_rdy is low, bus_cyc, bus_addr and bus_be hold their values.
- R6: Only after all lines of both caches are invalidated, a special cycle runs with bus_be = F7h, bus_addr = 0, bus_wr = 1, bus_mem = 1 and bus_data = 0. It is held until bus_rdy.
- R7: In the clock after the F7h cycle's ready, a second special cycle runs with bus_be = FDh and the same address and flags. It needs its own bus_rdy.
- R8: flush_done is high for exactly one clock: the clock after the FDh cycle's ready.
- R9: flush_req is ignored everywhere except the idle state. A request held high through a whole flush, including the done clock, yields one sweep and one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush_req | input | 1 | Flush command, sampled in idle |
| flush_done | output | 1 | One-clock completion pulse |
| dc_idx | output | 7 | Data cache line index being examined |
| dc_modified | input | 1 | Modified state of the data line at dc_idx |
| dc_tag | input | 27 | Line address bits 31:5 of the data line at dc_idx |
| dc_inval | output | 1 | Invalidate the data line at dc_idx |
| ic_idx | output | 7 | Instruction cache line index |
| ic_inval | output | 1 | Invalidate the instruction line at ic_idx |
| ld_beat | output | 2 | Beat selector into the data line at dc_idx |
| ld_data | input | 64 | Line data for dc_idx and ld_beat |
| bus_cyc | output | 1 | Bus cycle active |
| bus_addr | output | 29 | Beat address bits 31:3 |
| bus_be | output | 8 | Byte enables BE7..BE0 |
| bus_wdata | output | 64 | Write data |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_mem | output | 1 | 1 = memory, 0 = I/O |
| bus_data | output | 1 | 1 = data, 0 = control (special cycle) |
| bus_rdy | input | 1 | Ready from the system |

## Verification
The collision of interest is a flush command arriving while a sweep is finishing. That covers the FDh ready edge and the done clock, where a careless controller would restart or stretch the done pulse. The bench holds flush_req high from the start of a flush until it has seen flush_done. It then watches twenty more clocks, and expects exactly one done pulse, no further invalidate strobes and no further bus cycles. Other runs combine random dirty patterns with random or mostly-low ready. A writeback stall can then fall on any beat, including those of the first and last data lines.

// File: rtl/cfs_pkg.sv
// Package: shared state encoding and byte-enable codes for the flush sequencer.
// Assumes one 32-byte line per tag entry and a 64-bit data bus.
package cfs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DSCAN,
        ST_WB,
        ST_DINV,
        ST_ISCAN,
        ST_SPC1,
        ST_SPC2,
        ST_DONE
    } cfs_state_t;

    localparam logic [7:0] BE_WBINV = 8'hF7;
    localparam logic [7:0] BE_INVAL = 8'hFD;
    localparam logic [7:0] BE_FULL  = 8'hFF;
endpackage

// File: rtl/cfs_step_ctr.sv
// Module: wrapping up-counter used for the line index and for the burst beat.
// Assumes LIMIT >= 2. at_last flags the final count; an increment there wraps to 0.
module cfs_step_ctr #(
    parameter int LIMIT = 128,
    localparam int W = $clog2(LIMIT)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         at_last
);
    // Flag the final count of the range.
    assign at_last = (cnt == W'(LIMIT - 1));

    // Clear, step or wrap the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (inc)
            cnt <= at_last ? '0 : cnt + 1'b1;
    end

    // R2
    ctr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && at_last && !clr) |=> (cnt == '0));
endmodule

// File: rtl/cfs_bus_mux.sv
// Module: forms the bus master outputs from the sequencer state.
// Assumes the state, tag, beat and line data are all stable for a whole cycle.
// Writebacks are data-type memory writes; special cycles are control-type memory
// writes at address zero.
module cfs_bus_mux
    import cfs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int TAG_W  = 27,
    parameter int BEAT_W = 2,
    localparam int OFS_W = $clog2(DATA_W / 8)
) (
    input  cfs_state_t             state,
    input  logic [TAG_W-1:0]       tag,
    input  logic [BEAT_W-1:0]      beat,
    input  logic [DATA_W-1:0]      line_data,
    output logic                   bus_cyc,
    output logic [ADDR_W-1:OFS_W]  bus_addr,
    output logic [7:0]             bus_be,
    output logic [DATA_W-1:0]      bus_wdata,
    output logic                   bus_wr,
    output logic                   bus_mem,
    output logic                   bus_data
);
    // Decode the bus fields for the current state.
    always_comb begin
        bus_cyc   = 1'b0;
        bus_addr  = '0;
        bus_be    = BE_FULL;
        bus_wdata = '0;
        bus_wr    = 1'b0;
        bus_mem   = 1'b0;
        bus_data  = 1'b0;
        case (state)
            ST_WB: begin
                bus_cyc   = 1'b1;
                bus_addr  = {tag, beat};
                bus_wdata = line_data;
                bus_wr    = 1'b1;
                bus_mem   = 1'b1;
                bus_data  = 1'b1;
            end
            ST_SPC1, ST_SPC2: begin
                bus_cyc = 1'b1;
                bus_be  = (state == ST_SPC1) ? BE_WBINV : BE_INVAL;
                bus_wr  = 1'b1;
                bus_mem = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cflush_sequencer.sv
// Module: cache writeback-and-invalidate sequencer (top).
// Walks the data cache, writing back modified lines as 4-beat bursts before
// invalidating them. Then walks the instruction cache, and then runs the F7h and FDh
// special cycles, each waiting for its own ready. Assumes combinational tag and
// line-data reads and two caches of equal line count.
module cflush_sequencer
    import cfs_pkg::*;
#(
    parameter int LINES      = 128,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int LINE_BYTES = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int BEATS  = LINE_BYTES / (DATA_W / 8),
    localparam int BEAT_W = $clog2(BEATS),
    localparam int OFS_W  = $clog2(DATA_W / 8),
    localparam int TAG_W  = ADDR_W - $clog2(LINE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush_req,
    output logic                  flush_done,
    output logic [IDX_W-1:0]      dc_idx,
    input  logic                  dc_modified,
    input  logic [TAG_W-1:0]      dc_tag,
    output logic                  dc_inval,
    output logic [IDX_W-1:0]      ic_idx,
    output logic                  ic_inval,
    output logic [BEAT_W-1:0]     ld_beat,
    input  logic [DATA_W-1:0]     ld_data,
    output logic                  bus_cyc,
    output logic [ADDR_W-1:OFS_W] bus_addr,
    output logic [7:0]            bus_be,
    output logic [DATA_W-1:0]     bus_wdata,
    output logic                  bus_wr,
    output logic                  bus_mem,
    output logic                  bus_data,
    input  logic                  bus_rdy
);
    cfs_state_t        state, state_nx;
    logic              idx_clr, idx_inc, idx_last;
    logic              beat_clr, beat_inc, beat_last;
    logic [IDX_W-1:0]  idx;
    logic [BEAT_W-1:0] beat;

    cfs_step_ctr #(.LIMIT(LINES)) u_idx (
        .clk(clk), .rst_n(rst_n), .clr(idx_clr), .inc(idx_inc),
        .cnt(idx), .at_last(idx_last)
    );

    cfs_step_ctr #(.LIMIT(BEATS)) u_beat (
        .clk(clk), .rst_n(rst_n), .clr(beat_clr), .inc(beat_inc),
        .cnt(beat), .at_last(beat_last)
    );

    cfs_bus_mux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .BEAT_W(BEAT_W)
    ) u_mux (
        .state(state), .tag(dc_tag), .beat(beat), .line_data(ld_data),
        .bus_cyc(bus_cyc), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_mem(bus_mem),
        .bus_data(bus_data)
    );

    // Next-state and strobe decode for the sweep.
    always_comb begin
        state_nx = state;
        idx_clr  = (state == ST_IDLE);
        beat_clr = (state == ST_IDLE);
        idx_inc  = 1'b0;
        beat_inc = 1'b0;
        dc_inval = 1'b0;
        ic_inval = 1'b0;
        case (state)
            ST_IDLE:  if (flush_req) state_nx = ST_DSCAN;
            ST_DSCAN: begin
                if (dc_modified) begin
                    state_nx = ST_WB;
                end else begin
                    dc_inval = 1'b1;
                    idx_inc  = 1'b1;
                    if (idx_last) state_nx = ST_ISCAN;
                end
            end
            ST_WB: begin
                if (bus_rdy) begin
                    beat_inc = 1'b1;
                    if (beat_last) state_nx = ST_DINV;
                end
            end
            ST_DINV: begin
                dc_inval = 1'b1;
                idx_inc  = 1'b1;
                state_nx = idx_last ? ST_ISCAN : ST_DSCAN;
            end
            ST_ISCAN: begin
                ic_inval = 1'b1;
                idx_inc  = 1'b1;
                if (idx_last) state_nx = ST_SPC1;
            end
            ST_SPC1:  if (bus_rdy) state_nx = ST_SPC2;
            ST_SPC2:  if (bus_rdy) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign dc_idx     = idx;
    assign ic_idx     = idx;
    assign ld_beat    = beat;
    assign flush_done = (state == ST_DONE);

    // R2
    one_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dc_inval && ic_inval));
    // R3
    no_inval_on_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> (!dc_inval && !ic_inval));
    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_rdy) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_be)));
    // R7
    spc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_be == BE_WBINV && bus_rdy) |=> (bus_cyc && bus_be == BE_INVAL));
    // R8
    done_after_fd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_be == BE_INVAL && bus_rdy) |=> flush_done);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done);
    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_done && flush_req) |=> !bus_cyc && !dc_inval);
endmodule

// File: tb/tb_cflush_sequencer.sv
// Bench: random dirty patterns and ready stalls plus directed corner cases,
// checked by a negedge monitor against expectations built from the bench's tag store.
module tb_cflush_sequencer;
    localparam int LINES = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_req = 1'b0;
    logic        flush_done;
    logic [6:0]  dc_idx, ic_idx;
    logic        dc_modified;
    logic [26:0] dc_tag;
    logic        dc_inval, ic_inval;
    logic [1:0]  ld_beat;
    logic [63:0] ld_data;
    logic        bus_cyc;
    logic [31:3] bus_addr;
    logic [7:0]  bus_be;
    logic [63:0] bus_wdata;
    logic        bus_wr, bus_mem, bus_data;
    logic        bus_rdy = 1'b0;

    bit          snap_mod [LINES];
    logic [26:0] tag_mem  [LINES];

    int checks = 0, fails = 0;
    int rdy_mode = 0;
    bit mon_en = 0;
    int dc_cnt, ic_cnt, spc_cnt, beats_line, wb_total, done_cnt;
    bit stall_prev = 0, fd_prev = 0;
    logic [31:3] prev_addr;
    logic [7:0]  prev_be;

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [63:0] line_word(input int idx, input int beat);
        return {24'h5A0F1E, 1'b0, 7'(idx), 6'b0, 2'(beat), 24'hC3B2A1};
    endfunction

    assign dc_modified = snap_mod[dc_idx];
    assign dc_tag      = tag_mem[dc_idx];
    assign ld_data     = line_word(int'(dc_idx), int'(ld_beat));

    cflush_sequencer dut (
        .clk(clk), .rst_n(rst_n), .flush_req(flush_req), .flush_done(flush_done),
        .dc_idx(dc_idx), .dc_modified(dc_modified), .dc_tag(dc_tag), .dc_inval(dc_inval),
        .ic_idx(ic_idx), .ic_inval(ic_inval), .ld_beat(ld_beat), .ld_data(ld_data),
        .bus_cyc(bus_cyc), .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_mem(bus_mem), .bus_data(bus_data), .bus_rdy(bus_rdy)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: choose ready for the coming edge, then judge the cycle.
    always @(negedge clk) begin
        bit r;
        case (rdy_mode)
            0:       r = 1'b1;
            1:       r = ($urandom_range(0, 1) == 1);
            default: r = ($urandom_range(0, 3) == 0);
        endcase
        bus_rdy = r;
        if (rst_n && mon_en) begin
            if (stall_prev)   // R5: held through a stall
                chk(bus_cyc && bus_addr == prev_addr && bus_be == prev_be, "R5 hold",
                    {27'b0, bus_cyc, bus_addr, bus_be}, {27'b0, 1'b1, prev_addr, prev_be});
            stall_prev = bus_cyc && !r;
            prev_addr  = bus_addr;
            prev_be    = bus_be;
            if (fd_prev) chk(flush_done, "R8 done after FDh ready", 64'(flush_done), 64'd1);
            else if (flush_done) chk(1'b0, "R8 stray done", 64'd1, 64'd0);
            fd_prev = 1'b0;
            if (flush_done) begin
                done_cnt++;
                chk(dc_cnt == LINES && ic_cnt == LINES && spc_cnt == 2, "R2 R7 complete at done",
                    64'(dc_cnt + ic_cnt + spc_cnt), 64'(2 * LINES + 2));
            end
            if (dc_inval) begin
                chk(int'(dc_idx) == dc_cnt && ic_cnt == 0, "R2 data order",
                    64'(dc_idx), 64'(dc_cnt));
                if (dc_cnt < LINES)
                    chk(beats_line == (snap_mod[dc_cnt] ? 4 : 0), "R3 beats before inval",
                        64'(beats_line), snap_mod[dc_cnt] ? 64'd4 : 64'd0);
                beats_line = 0;
                dc_cnt++;
            end
            if (ic_inval) begin
                chk(int'(ic_idx) == ic_cnt && dc_cnt == LINES, "R2 instr order",
                    64'(ic_idx), 64'(ic_cnt));
                ic_cnt++;
            end
            if (bus_cyc && r) begin
                if (bus_data) begin
                    if (dc_cnt < LINES) begin
                        chk(snap_mod[dc_cnt] && beats_line < 4, "R3 writeback only if modified",
                            64'(beats_line), 64'd0);
                        chk(bus_addr == {tag_mem[dc_cnt], 2'(beats_line)}, "R4 address",
                            64'(bus_addr), 64'({tag_mem[dc_cnt], 2'(beats_line)}));
                        chk(bus_wdata == line_word(dc_cnt, beats_line), "R4 data",
                            bus_wdata, line_word(dc_cnt, beats_line));
                    end else begin
                        chk(1'b0, "R3 writeback after data sweep", 64'(dc_cnt), 64'(LINES));
                    end
                    chk(bus_be == 8'hFF && bus_wr && bus_mem, "R4 flags",
                        {53'b0, bus_be, bus_wr, bus_mem, bus_data}, {53'b0, 8'hFF, 3'b111});
                    beats_line++;
                    wb_total++;
                end else begin
                    chk(dc_cnt == LINES && ic_cnt == LINES, "R6 special after sweep",
                        64'(dc_cnt + ic_cnt), 64'(2 * LINES));
                    chk(bus_be == ((spc_cnt == 0) ? 8'hF7 : 8'hFD), "R6 R7 byte enables",
                        64'(bus_be), (spc_cnt == 0) ? 64'hF7 : 64'hFD);
                    chk(bus_addr == '0 && bus_wr && bus_mem, "R6 special flags",
                        {34'b0, bus_addr, bus_wr}, {34'b0, 29'b0, 1'b1});
                    if (spc_cnt == 1) fd_prev = 1'b1;
                    spc_cnt++;
                end
            end
        end
    end

    task automatic run_flush(input int mode, input int pct, input bit hold_req,
                             input bit edges_only);
        int nmod = 0;
        int t = 0;
        for (int i = 0; i < LINES; i++) begin
            tag_mem[i]  = 27'($urandom);
            snap_mod[i] = edges_only ? (i == 0 || i == LINES - 1)
                                     : ($urandom_range(0, 99) < pct);
            if (snap_mod[i]) nmod++;
        end
        dc_cnt = 0; ic_cnt = 0; spc_cnt = 0; beats_line = 0; wb_total = 0; done_cnt = 0;
        rdy_mode = mode;
        @(negedge clk);
        flush_req = 1'b1;
        if (!hold_req) begin
            @(negedge clk);
            flush_req = 1'b0;
            repeat (5) @(negedge clk);
            flush_req = 1'b1;   // R9: mid-sweep request
            @(negedge clk);
            flush_req = 1'b0;
        end
        while (done_cnt == 0 && t < 30000) begin
            @(posedge clk);
            t++;
        end
        chk(t < 30000, "R8 flush finished", 64'(t), 64'd30000);
        @(negedge clk);
        flush_req = 1'b0;
        repeat (20) @(negedge clk);
        chk(done_cnt == 1, "R9 single done", 64'(done_cnt), 64'd1);
        chk(dc_cnt == LINES && ic_cnt == LINES, "R2 all lines once",
            64'(dc_cnt + ic_cnt), 64'(2 * LINES));
        chk(wb_total == 4 * nmod, "R3 burst count", 64'(wb_total), 64'(4 * nmod));
        chk(spc_cnt == 2, "R7 two special cycles", 64'(spc_cnt), 64'd2);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!bus_cyc && !flush_done && !dc_inval && !ic_inval, "R1 reset state",
            {60'b0, bus_cyc, flush_done, dc_inval, ic_inval}, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!bus_cyc && !flush_done && !dc_inval && !ic_inval, "R1 idle state",
            {60'b0, bus_cyc, flush_done, dc_inval, ic_inval}, 64'd0);
        mon_en = 1'b1;
        run_flush(0, 0, 1'b0, 1'b0);     // all clean, ready always high
        run_flush(1, 25, 1'b0, 1'b0);    // random dirty, random ready
        run_flush(2, 0, 1'b1, 1'b1);     // first and last lines dirty, request held (R9)
        run_flush(1, 100, 1'b0, 1'b0);   // every line dirty
        run_flush(2, 50, 1'b1, 1'b0);    // heavy stalls, request held (R9)
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule